// File: doc/BRIEF.md
# HDLC Transmit Bit Framer

This block serialises a stream of message bytes into an HDLC bit stream. A byte source offers one byte at a time with a valid qualifier and an end-of-message tag. The framer wraps each message in flag octets and inserts a zero after every run of five ones in the payload. It can append a 16-bit frame check sequence, and it fills the line with a selectable idle pattern between messages. When the source runs dry in the middle of a message, or when software asks for it, the framer ends the message with an abort.

The framer moves forward one line bit per `bitEn` strobe, so a slower line clock can be gated in from the system clock. All decisions are taken at octet boundaries. When an octet's last bit has gone out (and any pending inserted zero with it), the next octet is picked in the same strobe that sends its first bit. A data byte is accepted in that strobe with a one-cycle `inReady` pulse. Channel mapping onto a TDM line is left to the surrounding logic.

Top module: `hdlcTxFramer`

## Requirements
- R1: While `rstN` is low, and until the first `bitEn` strobe after it, `txBit` is 1 and `msgDone`, `underrun` and `inReady` are 0.
- R2: `txBit` changes only on a clock with `bitEn` high and holds its value on every other clock. Every octet goes out least significant bit first.
- R3: With no message pending, the line carries whole idle octets: 0x7E when `cfgFillOnes` is 0, and 0xFF when it is 1.
- R4: A message is sent as an opening flag 0x7E, its bytes, the optional check sequence and a closing flag 0x7E. If the next message's first byte is valid when the closing flag ends, that message follows directly. It starts after the closing flag alone when `cfgTwoFlags` is 0, and after one further opening flag when it is 1. Otherwise idle octets follow.
- R5: After five consecutive 1 bits taken from data or check-sequence octets, a 0 is inserted that consumes no source bit. When `cfgNoStuff` is 1, nothing is inserted. Flag, idle and abort octets are never stuffed and do not count toward the run.
- R6: When `cfgNoCrc` is 0, two check octets follow the last data byte. The check register is preset to 0xFFFF and fed data bits in line order with the reflected polynomial x^16+x^12+x^5+1. Its ones' complement is sent low octet first, each octet least significant bit first, so the bytes "123456789" give 0x906E. When `cfgNoCrc` is 1, the closing flag follows the last data byte.
- R7: If a data byte is needed after the opening flag, or after a byte without the end tag, and `inValid` is low, an abort octet 0xFF is sent unstuffed. It is followed by at least one idle octet. `underrun` pulses for one clock in the strobe that starts the abort.
- R8: An `abortReq` pulse seen while an opening flag, data or check octet is in flight replaces the next octet with the 0xFF abort, followed by idle. It raises neither `underrun` nor `msgDone`. An `abortReq` during idle, closing-flag or abort octets is ignored.
- R9: `msgDone` pulses for one clock in the strobe that starts a closing flag, once per completed message.
- R10: `inReady` is high only together with `bitEn` and `inValid`, exactly in the strobes that load a data byte. `inEom` is sampled with that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-line-bit advance strobe |
| inData | input | 8 | Offered message byte |
| inValid | input | 1 | `inData` holds a byte |
| inEom | input | 1 | Offered byte ends its message |
| inReady | output | 1 | Offered byte is taken this clock |
| cfgTwoFlags | input | 1 | Opening flag added between back-to-back messages |
| cfgFillOnes | input | 1 | Idle octet is 0xFF instead of 0x7E |
| cfgNoStuff | input | 1 | Disable zero insertion |
| cfgNoCrc | input | 1 | Suppress the check sequence |
| abortReq | input | 1 | Software abort request pulse |
| txBit | output | 1 | Serial line bit |
| msgDone | output | 1 | Closing flag started (pulse) |
| underrun | output | 1 | Abort caused by empty source (pulse) |

## Verification
The assertions assume that the byte source keeps `inData` and `inEom` steady while `inValid` is high until the byte is taken. They also assume that `abortReq` is a single-clock pulse. The checks on the `inReady` handshake and on single-clock status pulses rely on these assumptions. The stimulus drives the source straight from a byte queue and raises `abortReq` for only one clock. It changes configuration bits only while the line is idle, so no octet is ever formed under mixed settings. The reference model compares the line bit, both pulses and the accept strobe on every clock, with dense and with sparse `bitEn` patterns.

// File: rtl/hdlcTxPkg.sv
package hdlcTxPkg;

  localparam int OCT_W = 8;
  localparam int LEFT_W = $clog2(OCT_W);
  localparam logic [OCT_W-1:0] FLAG_OCT = 8'h7E;
  localparam logic [OCT_W-1:0] ONES_OCT = 8'hFF;

  localparam int FCS_W = 16;
  localparam logic [FCS_W-1:0] FCS_POLY_REV = 16'h8408;
  localparam logic [FCS_W-1:0] FCS_INIT = 16'hFFFF;

  // Octet kinds; the control moves between them at octet boundaries
  typedef enum logic [2:0] {
    K_FILL,
    K_OPEN,
    K_DATA,
    K_FCSLO,
    K_FCSHI,
    K_CLOSE,
    K_ABORT
  } octKind_e;

  // Per-clock strobes from control to datapath
  typedef struct packed {
    logic     load;       // start a new octet with its first bit
    logic     shift;      // send next bit of current octet
    logic     insZero;    // send an inserted zero
    octKind_e src;        // source of the octet being loaded
    logic     stuffOn;    // emitted bit counts toward the ones run
    logic     crcPreset;  // restart the check register
    logic     crcRun;     // emitted bit feeds the check register
    logic     markDone;   // closing flag starts
    logic     markUnder;  // abort caused by empty source starts
  } bitStrobe_t;

  function automatic logic [FCS_W-1:0] fcsStep(input logic [FCS_W-1:0] cur, input logic b);
    logic [FCS_W-1:0] sh;
    sh = cur >> 1;
    return (cur[0] ^ b) ? (sh ^ FCS_POLY_REV) : sh;
  endfunction

endpackage

// File: rtl/hdlcTxCtrl.sv
module hdlcTxCtrl
  import hdlcTxPkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       inValid,
  input  logic       inEom,
  input  logic       abortReq,
  input  logic       cfgTwoFlags,
  input  logic       cfgNoStuff,
  input  logic       cfgNoCrc,
  input  logic       onesFull,
  output bitStrobe_t stb,
  output logic       inReady
);

  octKind_e          kindQ, nextKind;
  logic [LEFT_W-1:0] leftQ;
  logic              lastEomQ;
  logic              pendQ, pendSet, pendNext;
  logic              curMsg, nextMsg, curStuffed, nextStuffed;
  logic              insZero, load, abortNow, underNow;

  function automatic logic isMsg(input octKind_e k);
    return (k == K_OPEN) || (k == K_DATA) || (k == K_FCSLO) || (k == K_FCSHI);
  endfunction

  function automatic logic isStuffed(input octKind_e k, input logic noStuff);
    return !noStuff && ((k == K_DATA) || (k == K_FCSLO) || (k == K_FCSHI));
  endfunction

  assign curMsg      = isMsg(kindQ);
  assign curStuffed  = isStuffed(kindQ, cfgNoStuff);
  assign insZero     = bitEn && curStuffed && onesFull;
  assign load        = bitEn && !insZero && (leftQ == '0);
  assign abortNow    = curMsg && (pendQ || abortReq);

  // Next-octet decision, used only when an octet boundary is reached
  always_comb begin
    nextKind = kindQ;
    underNow = 1'b0;
    unique case (kindQ)
      K_FILL:  nextKind = inValid ? K_OPEN : K_FILL;
      K_OPEN: begin
        if (abortNow) nextKind = K_ABORT;
        else if (inValid) nextKind = K_DATA;
        else begin
          nextKind = K_ABORT;
          underNow = 1'b1;
        end
      end
      K_DATA: begin
        if (abortNow) nextKind = K_ABORT;
        else if (lastEomQ) nextKind = cfgNoCrc ? K_CLOSE : K_FCSLO;
        else if (inValid) nextKind = K_DATA;
        else begin
          nextKind = K_ABORT;
          underNow = 1'b1;
        end
      end
      K_FCSLO: nextKind = abortNow ? K_ABORT : K_FCSHI;
      K_FCSHI: nextKind = abortNow ? K_ABORT : K_CLOSE;
      K_CLOSE: begin
        if (!inValid) nextKind = K_FILL;
        else nextKind = cfgTwoFlags ? K_OPEN : K_DATA;
      end
      K_ABORT: nextKind = K_FILL;
      default: nextKind = K_FILL;
    endcase
  end

  assign nextMsg     = isMsg(nextKind);
  assign nextStuffed = isStuffed(nextKind, cfgNoStuff);

  always_comb begin
    stb.load      = load;
    stb.shift     = bitEn && !insZero && !load;
    stb.insZero   = insZero;
    stb.src       = load ? nextKind : kindQ;
    stb.stuffOn   = load ? nextStuffed : curStuffed;
    stb.crcPreset = load && (nextKind == K_DATA) && (kindQ != K_DATA);
    stb.crcRun    = bitEn && !insZero && (load ? (nextKind == K_DATA) : (kindQ == K_DATA));
    stb.markDone  = load && (nextKind == K_CLOSE);
    stb.markUnder = load && underNow;
  end

  assign inReady = load && (nextKind == K_DATA);

  // A pending abort survives only while the message is still in flight
  assign pendSet  = pendQ || (abortReq && curMsg);
  assign pendNext = load ? (pendSet && nextMsg) : pendSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ    <= K_FILL;
      leftQ    <= '0;
      lastEomQ <= 1'b0;
      pendQ    <= 1'b0;
    end else begin
      pendQ <= pendNext;
      if (load) begin
        kindQ <= nextKind;
        leftQ <= LEFT_W'(OCT_W - 1);
        if (nextKind == K_DATA) lastEomQ <= inEom;
      end else if (stb.shift) begin
        leftQ <= leftQ - 1'b1;
      end
    end
  end

endmodule

// File: rtl/hdlcTxData.sv
module hdlcTxData
  import hdlcTxPkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  bitStrobe_t       stb,
  input  logic [OCT_W-1:0] inData,
  input  logic             cfgFillOnes,
  output logic             txBit,
  output logic             msgDone,
  output logic             underrun,
  output logic             onesFull
);

  localparam int ONES_W = $clog2(STUFF_RUN + 1);

  logic [OCT_W-1:0]  shQ;
  logic [OCT_W-1:0]  srcByte;
  logic [FCS_W-1:0]  crcQ, crcBase;
  logic [ONES_W-1:0] onesQ;
  logic              curBit, slot;

  always_comb begin
    unique case (stb.src)
      K_FILL:  srcByte = cfgFillOnes ? ONES_OCT : FLAG_OCT;
      K_DATA:  srcByte = inData;
      K_FCSLO: srcByte = ~crcQ[OCT_W-1:0];
      K_FCSHI: srcByte = ~crcQ[FCS_W-1:OCT_W];
      K_ABORT: srcByte = ONES_OCT;
      default: srcByte = FLAG_OCT;
    endcase
  end

  assign slot     = stb.load || stb.shift || stb.insZero;
  assign curBit   = stb.insZero ? 1'b0 : (stb.load ? srcByte[0] : shQ[0]);
  assign crcBase  = stb.crcPreset ? FCS_INIT : crcQ;
  assign onesFull = (onesQ == ONES_W'(STUFF_RUN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shQ      <= '0;
      txBit    <= 1'b1;
      onesQ    <= '0;
      crcQ     <= FCS_INIT;
      msgDone  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      msgDone  <= stb.markDone;
      underrun <= stb.markUnder;
      if (stb.load) shQ <= {1'b0, srcByte[OCT_W-1:1]};
      else if (stb.shift) shQ <= shQ >> 1;
      if (slot) begin
        txBit <= curBit;
        onesQ <= (stb.stuffOn && !stb.insZero && curBit) ? onesQ + 1'b1 : '0;
      end
      if (stb.crcRun) crcQ <= fcsStep(crcBase, curBit);
    end
  end

endmodule

// File: rtl/hdlcTxFramer.sv
module hdlcTxFramer
  import hdlcTxPkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic [OCT_W-1:0] inData,
  input  logic             inValid,
  input  logic             inEom,
  output logic             inReady,
  input  logic             cfgTwoFlags,
  input  logic             cfgFillOnes,
  input  logic             cfgNoStuff,
  input  logic             cfgNoCrc,
  input  logic             abortReq,
  output logic             txBit,
  output logic             msgDone,
  output logic             underrun
);

  bitStrobe_t stb;
  logic       onesFull;

  hdlcTxCtrl #(.STUFF_RUN(STUFF_RUN)) i_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .inValid(inValid), .inEom(inEom),
    .abortReq(abortReq), .cfgTwoFlags(cfgTwoFlags), .cfgNoStuff(cfgNoStuff),
    .cfgNoCrc(cfgNoCrc), .onesFull(onesFull), .stb(stb), .inReady(inReady)
  );

  hdlcTxData #(.STUFF_RUN(STUFF_RUN)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .cfgFillOnes(cfgFillOnes),
    .txBit(txBit), .msgDone(msgDone), .underrun(underrun), .onesFull(onesFull)
  );

endmodule

// File: rtl/hdlcTxChecker.sv
module hdlcTxChecker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic inValid,
  input logic inReady,
  input logic txBit,
  input logic msgDone,
  input logic underrun
);

  // R2: line bit frozen between strobes
  a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txBit));

  // R10: a byte is taken only on a strobe with a valid byte
  a_r10_accept_qualified: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (bitEn && inValid));

  // R9: message-done lasts one clock and follows a strobe
  a_r9_done_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |=> !msgDone);
  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |-> $past(bitEn));

  // R7: underrun lasts one clock and never coincides with message-done
  a_r7_underrun_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun);
  a_r7_underrun_not_done: assert property (@(posedge clk) disable iff (!rstN)
    !(underrun && msgDone));

endmodule

bind hdlcTxFramer hdlcTxChecker i_hdlcTxChecker (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .inValid(inValid), .inReady(inReady),
  .txBit(txBit), .msgDone(msgDone), .underrun(underrun)
);

// File: tb/test_hdlcTxFramer.sv
module test_hdlcTxFramer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inEom = 1'b0;
  logic       inReady;
  logic       cfgTwoFlags = 1'b0;
  logic       cfgFillOnes = 1'b0;
  logic       cfgNoStuff = 1'b0;
  logic       cfgNoCrc = 1'b0;
  logic       abortReq = 1'b0;
  logic       txBit, msgDone, underrun;

  always #4 clk = ~clk;

  hdlcTxFramer i_hdlcTxFramer (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .inData(inData), .inValid(inValid),
    .inEom(inEom), .inReady(inReady), .cfgTwoFlags(cfgTwoFlags),
    .cfgFillOnes(cfgFillOnes), .cfgNoStuff(cfgNoStuff), .cfgNoCrc(cfgNoCrc),
    .abortReq(abortReq), .txBit(txBit), .msgDone(msgDone), .underrun(underrun)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // byte source
  logic [7:0] srcData[$];
  logic       srcEom[$];
  int         enDiv = 1;
  int         divCnt = 0;
  logic       swPulse = 1'b0;

  // behavioural line model: kinds 0 idle,1 open,2 data,3 fcs lo,4 fcs hi,5 close,6 abort
  int         mKind = 0;
  logic       mBits[$];
  int         mOnes = 0;
  logic [15:0] mCrc = 16'hFFFF;
  logic       mLastEom = 1'b0;
  logic       mPend = 1'b0;
  logic       mAbortSw = 1'b0;
  logic       mSwTaken = 1'b0;
  logic       expTx = 1'b1, expDone = 1'b0, expUnder = 1'b0, expPop = 1'b0;
  string      mTag = "R1 reset line";

  // observation counters per phase
  int doneSeen = 0, underSeen = 0, runNow = 0, runMax = 0;
  logic lastEn = 1'b0;

  function automatic logic [15:0] crcBitRef(input logic [15:0] c, input logic b);
    logic [15:0] r;
    r = {1'b0, c[15:1]};
    if (c[0] != b) r = r ^ 16'h8408;
    return r;
  endfunction

  function automatic logic [15:0] fcsOfBytes(input logic [7:0] bytes[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (bytes[i]) for (int k = 0; k < 8; k++) c = crcBitRef(c, bytes[i][k]);
    return ~c;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelStep();
    logic msgK, reqNow, loaded, stf, bv, und, sw;
    int nk;
    logic [7:0] b;
    msgK = (mKind >= 1 && mKind <= 4);
    reqNow = msgK && (mPend || abortReq);
    loaded = 1'b0;
    expDone = 1'b0; expUnder = 1'b0; expPop = 1'b0; mSwTaken = 1'b0;
    if (bitEn) begin
      stf = (mKind >= 2 && mKind <= 4) && !cfgNoStuff;
      if (stf && mOnes == 5) begin
        expTx = 1'b0;
        mOnes = 0;
        mTag = "R5 inserted zero";
      end else begin
        if (mBits.size() == 0) begin
          und = 1'b0; sw = 1'b0; nk = 0; b = 8'h7E;
          case (mKind)
            0: nk = inValid ? 1 : 0;
            1: if (reqNow) begin nk = 6; sw = 1; end
               else if (inValid) nk = 2;
               else begin nk = 6; und = 1; end
            2: if (reqNow) begin nk = 6; sw = 1; end
               else if (mLastEom) nk = cfgNoCrc ? 5 : 3;
               else if (inValid) nk = 2;
               else begin nk = 6; und = 1; end
            3: if (reqNow) begin nk = 6; sw = 1; end else nk = 4;
            4: if (reqNow) begin nk = 6; sw = 1; end else nk = 5;
            5: nk = !inValid ? 0 : (cfgTwoFlags ? 1 : 2);
            default: nk = 0;
          endcase
          case (nk)
            0: b = cfgFillOnes ? 8'hFF : 8'h7E;
            2: begin
              if (mKind != 2) mCrc = 16'hFFFF;
              mLastEom = inEom;
              b = inData;
              expPop = 1'b1;
            end
            3: b = ~mCrc[7:0];
            4: b = ~mCrc[15:8];
            6: b = 8'hFF;
            default: b = 8'h7E;
          endcase
          for (int i = 0; i < 8; i++) mBits.push_back(b[i]);
          expUnder = und;
          expDone = (nk == 5);
          if (nk == 6) mAbortSw = sw;
          mSwTaken = sw;
          mKind = nk;
          loaded = 1'b1;
        end
        bv = mBits.pop_front();
        expTx = bv;
        stf = (mKind >= 2 && mKind <= 4) && !cfgNoStuff;
        mOnes = (stf && bv) ? mOnes + 1 : 0;
        if (mKind == 2) mCrc = crcBitRef(mCrc, bv);
        case (mKind)
          0: mTag = "R3 idle octet";
          1, 5: mTag = "R4 flag octet";
          2: mTag = "R2 data bit order";
          3, 4: mTag = "R6 check octet";
          default: mTag = mAbortSw ? "R8 software abort octet" : "R7 underrun abort octet";
        endcase
      end
    end
    msgK = msgK && 1'b1;
    if (loaded) mPend = (mPend || (abortReq && msgK)) && (mKind >= 1 && mKind <= 4);
    else mPend = mPend || (abortReq && msgK);
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    check(txBit === expTx, lastEn ? mTag : "R2 hold without strobe", 32'(txBit), 32'(expTx));
    check(msgDone === expDone, "R9 message done pulse", 32'(msgDone), 32'(expDone));
    check(underrun === expUnder, "R7 underrun pulse", 32'(underrun), 32'(expUnder));
    if (msgDone === 1'b1) doneSeen++;
    if (underrun === 1'b1) underSeen++;
    if (lastEn) begin
      if (txBit === 1'b1) runNow++; else runNow = 0;
      if (runNow > runMax) runMax = runNow;
    end
    bitEn = (divCnt == 0);
    divCnt = (divCnt + 1) % enDiv;
    lastEn = bitEn;
    inValid = (srcData.size() > 0);
    inData = inValid ? srcData[0] : 8'h00;
    inEom = inValid ? srcEom[0] : 1'b0;
    abortReq = swPulse;
    swPulse = 1'b0;
    #1;
    modelStep();
    check(inReady === expPop, "R10 byte accept strobe", 32'(inReady), 32'(expPop));
    if (expPop) begin
      void'(srcData.pop_front());
      void'(srcEom.pop_front());
    end
    if (mSwTaken) begin
      srcData.delete();
      srcEom.delete();
    end
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic settle();
    while (!(srcData.size() == 0 && mKind == 0 && mBits.size() == 0)) tick();
    runTicks(24 * enDiv);
  endtask

  task automatic pushByte(input logic [7:0] b, input logic eom);
    srcData.push_back(b);
    srcEom.push_back(eom);
  endtask

  task automatic newPhase();
    doneSeen = 0; underSeen = 0; runNow = 0; runMax = 0;
  endtask

  initial begin
    logic [7:0] vec[$];
    repeat (3) @(negedge clk);
    check(txBit === 1'b1, "R1 reset line level", 32'(txBit), 32'h1);
    check(msgDone === 1'b0, "R1 reset done low", 32'(msgDone), 32'h0);
    check(underrun === 1'b0, "R1 reset underrun low", 32'(underrun), 32'h0);
    check(inReady === 1'b0, "R1 reset accept low", 32'(inReady), 32'h0);
    rstN = 1'b1;

    // R6: reference vector for the check sequence
    vec = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    check(fcsOfBytes(vec) === 16'h906E, "R6 reference check value", 32'(fcsOfBytes(vec)), 32'h906E);

    // R3: idle flags, then idle ones
    newPhase(); runTicks(40);
    check(runMax <= 6, "R3 flag idle run", 32'(runMax), 32'd6);
    cfgFillOnes = 1'b1; runTicks(40);

    // R4/R9: one message with idle ones around it
    newPhase();
    pushByte(8'h12, 1'b0); pushByte(8'h34, 1'b1);
    settle();
    check(doneSeen == 1, "R9 one message done", 32'(doneSeen), 32'd1);

    // R4: back-to-back messages, single then double flag
    cfgFillOnes = 1'b0;
    for (int f = 0; f < 2; f++) begin
      cfgTwoFlags = f[0];
      newPhase();
      pushByte(8'hA5, 1'b1); pushByte(8'h5A, 1'b0); pushByte(8'hC3, 1'b1);
      settle();
      check(doneSeen == 2, "R4 back-to-back messages done", 32'(doneSeen), 32'd2);
    end

    // R5: stuffing on and off
    for (int s = 0; s < 2; s++) begin
      cfgNoStuff = s[0];
      newPhase();
      pushByte(8'hFF, 1'b0); pushByte(8'hFF, 1'b0); pushByte(8'h3E, 1'b0); pushByte(8'h7E, 1'b1);
      settle();
      if (s == 0) check(runMax <= 6, "R5 stuffed run limit", 32'(runMax), 32'd6);
      else check(runMax >= 8, "R5 unstuffed long run", 32'(runMax), 32'd8);
    end
    cfgNoStuff = 1'b0;

    // R6: reference bytes on the line, then with check suppressed
    newPhase();
    foreach (vec[i]) pushByte(vec[i], i == 8);
    settle();
    cfgNoCrc = 1'b1;
    newPhase();
    pushByte(8'h0F, 1'b0); pushByte(8'hF0, 1'b1);
    settle();
    check(doneSeen == 1, "R6 no-check message done", 32'(doneSeen), 32'd1);
    cfgNoCrc = 1'b0;

    // R7: source runs dry mid-message
    newPhase();
    pushByte(8'h11, 1'b0); pushByte(8'h22, 1'b0); pushByte(8'h33, 1'b0);
    settle();
    check(underSeen == 1, "R7 underrun count", 32'(underSeen), 32'd1);
    check(doneSeen == 0, "R7 no done after underrun", 32'(doneSeen), 32'd0);

    // R8: software abort mid-message
    newPhase();
    for (int i = 0; i < 20; i++) pushByte(8'((i * 3) & 8'h0F), i == 19);
    runTicks(40);
    swPulse = 1'b1;
    settle();
    check(underSeen == 0, "R8 abort raises no underrun", 32'(underSeen), 32'd0);
    check(doneSeen == 0, "R8 abort raises no done", 32'(doneSeen), 32'd0);
    check(runMax >= 8, "R8 abort ones visible", 32'(runMax), 32'd8);

    // R8: abort request while idle is ignored
    newPhase();
    runTicks(5);
    swPulse = 1'b1;
    runTicks(40);
    check(runMax <= 6, "R8 idle abort ignored", 32'(runMax), 32'd6);

    // R2: sparse strobes with a message
    enDiv = 3; divCnt = 0;
    cfgTwoFlags = 1'b1;
    newPhase();
    pushByte(8'h81, 1'b0); pushByte(8'hFE, 1'b0); pushByte(8'h01, 1'b1);
    settle();
    check(doneSeen == 1, "R2 sparse strobe message done", 32'(doneSeen), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule